// File: doc/BRIEF.md
# Ten's Complement BCD Adder-Subtractor

This block adds or subtracts two signed decimal operands. Each operand holds a fixed number of packed BCD digits, four bits per digit with the least significant digit in bits [3:0], and is read as a ten's complement integer. A single control input picks the operation. For a subtraction the block adds the nine's complement of every digit of the second operand and forces the carry into the lowest digit to 1. It therefore computes X + (-Y) with the same adder it uses for a sum.

The carries are resolved by a chain of 2-to-1 multiplexers. Each digit drives the chain with a decimal propagate flag (the digit pair sums to nine) and a decimal generate flag (the pair sums to ten or more). Both flags are taken straight from the operand bits, not from a binary partial sum. The upper three bits of each digit pair are pre-decoded twice, once for the plain second operand and once for its nine's complement, and the control selects between the two. After the chain, each digit adds its incoming carry and applies the +6 correction when its own carry-out is set.

The block is purely combinational. Besides the result digits it returns the raw carry out of the top digit and a signed overflow flag.

Top module: `bcd_addsub`

## Requirements
- R1: With opSub = 0 and valid BCD operands, resultDigits equals (X + Y) mod 10^N, where X and Y are the operands read as unsigned decimal numbers, and every result digit lies between 0 and 9.
- R2: With opSub = 1, resultDigits equals (X - Y) mod 10^N, where X and Y are read as unsigned decimal numbers.
- R3: overflow is 1 exactly when the signed result of the selected operation lies outside the representable range.
- R4: carryOut is the carry leaving the top digit. In add mode it is 1 when X + Y is at least 10^N. In subtract mode it is 1 when X is at least Y (no borrow).
- R5: An operand or result counts as negative when its top digit (bits [4N-1:4N-4]) is 5 or more. The representable range is -10^N/2 up to 10^N/2 - 1.
- R6: Subtracting the most negative value (top digit 5, all other digits 0) from zero returns that same digit pattern with overflow = 1.
- R7: A carry produced in the lowest digit travels through any number of digits that sum to nine: all nines plus one gives zero with carryOut = 1 and overflow = 0.
- R8: Subtracting an operand from itself gives zero, with carryOut = 1 and overflow = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opX | input | 4*DIGITS | First operand, packed BCD, ten's complement |
| opY | input | 4*DIGITS | Second operand, packed BCD, ten's complement |
| opSub | input | 1 | 0 selects X + Y, 1 selects X - Y |
| resultDigits | output | 4*DIGITS | Ten's complement BCD result |
| carryOut | output | 1 | Carry out of the most significant digit |
| overflow | output | 1 | Signed result outside the representable range |

## Verification
The assertions assume that every nibble of both operands is a legal BCD digit, from 0 to 9. They check nothing while an operand holds a code from 10 to 15, because the generate and propagate decode is only defined for legal digits. The stimulus builds every operand one digit at a time from values drawn between 0 and 9, and the directed cases are written as decimal integers and converted, so no illegal code ever reaches the ports.

// File: rtl/bcdas_pkg.sv
package bcdas_pkg;

  // Strobes the control half hands to the datapath.
  typedef struct packed {
    logic useNines;    // feed the nine's complement of Y into the adder
    logic forceCarry;  // carry into the lowest digit
  } addsubStrobes_t;

  // Nine's complement of one BCD digit (9 - d), valid for d in 0..9.
  function automatic logic [3:0] ninesDigit(input logic [3:0] d);
    ninesDigit = {~d[3] & ~d[2] & ~d[1], d[2] ^ d[1], d[1], ~d[0]};
  endfunction

  // Upper three bits of the nine's complement, taken from the upper bits alone.
  function automatic logic [2:0] ninesHigh(input logic [2:0] h);
    ninesHigh = {~h[2] & ~h[1] & ~h[0], h[1] ^ h[0], h[0]};
  endfunction

endpackage

// File: rtl/bcdas_ctrl.sv
module bcdas_ctrl
  import bcdas_pkg::*;
(
  input  logic           opSub,
  output addsubStrobes_t strobes
);

  always_comb begin
    strobes.useNines   = opSub;
    strobes.forceCarry = opSub;
  end

endmodule

// File: rtl/bcdas_gp_cell.sv
module bcdas_gp_cell
  import bcdas_pkg::*;
(
  input  logic [3:0] xDig,
  input  logic [3:0] yDig,
  input  logic       useNines,
  output logic       digProp,
  output logic       digGen
);

  logic [2:0] yHiNines;
  logic [3:0] hiSumPlain;
  logic [3:0] hiSumNines;
  logic       ppPlain, ggPlain, ppNines, ggNines;
  logic       ppSel, ggSel;
  logic       yLowEff;

  assign yHiNines   = ninesHigh(yDig[3:1]);
  assign hiSumPlain = {1'b0, xDig[3:1]} + {1'b0, yDig[3:1]};
  assign hiSumNines = {1'b0, xDig[3:1]} + {1'b0, yHiNines};

  // Upper-field flags: the fields sum to exactly four, or to five or more.
  assign ppPlain = (hiSumPlain == 4'd4);
  assign ggPlain = (hiSumPlain >= 4'd5);
  assign ppNines = (hiSumNines == 4'd4);
  assign ggNines = (hiSumNines >= 4'd5);

  assign ppSel   = useNines ? ppNines : ppPlain;
  assign ggSel   = useNines ? ggNines : ggPlain;

  // The low bit is complemented only here, at the final combination.
  assign yLowEff = yDig[0] ^ useNines;

  assign digProp = (xDig[0] ^ yLowEff) & ppSel;
  assign digGen  = ggSel | (ppSel & xDig[0] & yLowEff);

endmodule

// File: rtl/bcdas_carry_chain.sv
module bcdas_carry_chain #(
  parameter int DIGITS = 8
) (
  input  logic [DIGITS-1:0] digProp,
  input  logic [DIGITS-1:0] digGen,
  input  logic              carryIn,
  output logic [DIGITS:0]   carries
);

  assign carries[0] = carryIn;

  for (genvar i = 0; i < DIGITS; i++) begin : g_link
    assign carries[i+1] = digProp[i] ? carries[i] : digGen[i];
  end

endmodule

// File: rtl/bcdas_sum_cell.sv
module bcdas_sum_cell
  import bcdas_pkg::*;
(
  input  logic [3:0] xDig,
  input  logic [3:0] yDig,
  input  logic       useNines,
  input  logic       cIn,
  input  logic       cOut,
  output logic [3:0] zDig
);

  logic [3:0] yEff;
  logic [3:0] rawSum;

  assign yEff   = useNines ? ninesDigit(yDig) : yDig;
  assign rawSum = xDig + yEff + {3'b000, cIn};
  // A set digit carry-out means the true sum reached ten: add 6 modulo 16.
  assign zDig   = rawSum + (cOut ? 4'd6 : 4'd0);

endmodule

// File: rtl/bcdas_datapath.sv
module bcdas_datapath
  import bcdas_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] opX,
  input  logic [4*DIGITS-1:0] opY,
  input  addsubStrobes_t      strobes,
  output logic [4*DIGITS-1:0] resultDigits,
  output logic                carryOut,
  output logic                overflow
);

  localparam int TOP = 4 * DIGITS - 4;

  logic [DIGITS-1:0] digProp;
  logic [DIGITS-1:0] digGen;
  logic [DIGITS:0]   carries;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcdas_gp_cell u_gp (
      .xDig     (opX[4*d +: 4]),
      .yDig     (opY[4*d +: 4]),
      .useNines (strobes.useNines),
      .digProp  (digProp[d]),
      .digGen   (digGen[d])
    );

    bcdas_sum_cell u_sum (
      .xDig     (opX[4*d +: 4]),
      .yDig     (opY[4*d +: 4]),
      .useNines (strobes.useNines),
      .cIn      (carries[d]),
      .cOut     (carries[d+1]),
      .zDig     (resultDigits[4*d +: 4])
    );
  end

  bcdas_carry_chain #(.DIGITS(DIGITS)) u_chain (
    .digProp (digProp),
    .digGen  (digGen),
    .carryIn (strobes.forceCarry),
    .carries (carries)
  );

  assign carryOut = carries[DIGITS];

  // Sign classes of the effective operands and of the result.
  logic [3:0] yTopEff;
  logic       xNeg, yNeg, rNeg;

  assign yTopEff  = strobes.useNines ? ninesDigit(opY[TOP +: 4]) : opY[TOP +: 4];
  assign xNeg     = (opX[TOP +: 4] >= 4'd5);
  assign yNeg     = (yTopEff >= 4'd5);
  assign rNeg     = (resultDigits[TOP +: 4] >= 4'd5);
  assign overflow = (xNeg == yNeg) && (rNeg != xNeg);

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcdas_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input  logic [4*DIGITS-1:0] opX,
  input  logic [4*DIGITS-1:0] opY,
  input  logic                opSub,
  output logic [4*DIGITS-1:0] resultDigits,
  output logic                carryOut,
  output logic                overflow
);

  addsubStrobes_t strobes;

  bcdas_ctrl u_ctrl (
    .opSub   (opSub),
    .strobes (strobes)
  );

  bcdas_datapath #(.DIGITS(DIGITS)) u_dp (
    .opX          (opX),
    .opY          (opY),
    .strobes      (strobes),
    .resultDigits (resultDigits),
    .carryOut     (carryOut),
    .overflow     (overflow)
  );

endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int DIGITS = 8
) (
  input logic [4*DIGITS-1:0] opX,
  input logic [4*DIGITS-1:0] opY,
  input logic                opSub,
  input logic [4*DIGITS-1:0] resultDigits,
  input logic                carryOut,
  input logic                overflow
);

  function automatic longint pow10(input int n);
    longint acc;
    acc = 1;
    for (int i = 0; i < n; i++) acc = acc * 10;
    return acc;
  endfunction

  localparam longint MODULUS = pow10(DIGITS);

  function automatic logic allBcd(input logic [4*DIGITS-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint decVal(input logic [4*DIGITS-1:0] v);
    longint acc;
    acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic longint signedOf(input longint u);
    return (u >= MODULUS / 2) ? u - MODULUS : u;
  endfunction

  longint xv, yv, rv, expTotal, trueSigned;
  logic   ovfModel;

  always_comb begin
    xv         = decVal(opX);
    yv         = decVal(opY);
    rv         = decVal(resultDigits);
    expTotal   = opSub ? (xv + (MODULUS - 1 - yv) + 1) : (xv + yv);
    trueSigned = opSub ? (signedOf(xv) - signedOf(yv)) : (signedOf(xv) + signedOf(yv));
    ovfModel   = (trueSigned >= MODULUS / 2) || (trueSigned < -(MODULUS / 2));
    if (allBcd(opX) && allBcd(opY)) begin
      p_digits_valid_r1: assert (allBcd(resultDigits))
        else $error("result holds a non-decimal digit");
      // Carry and digits together match the decimal sum (R2, R4).
      p_value_r4: assert ((carryOut ? MODULUS : 64'sd0) + rv == expTotal)
        else $error("carry/result value mismatch");
      p_overflow_r3: assert (overflow == ovfModel)
        else $error("overflow flag mismatch");
      p_self_sub_r8: assert (!(opSub && (opX == opY)) || (rv == 0 && carryOut && !overflow))
        else $error("self subtraction not zero");
    end
  end

endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .opX          (opX),
  .opY          (opY),
  .opSub        (opSub),
  .resultDigits (resultDigits),
  .carryOut     (carryOut),
  .overflow     (overflow)
);

// File: tb/tb_bcd_addsub.sv
module tb_bcd_addsub;

  localparam int     DIGITS  = 8;
  localparam int     W       = 4 * DIGITS;
  localparam longint MODULUS = 64'd100000000;
  localparam longint HALF    = MODULUS / 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opX = '0;
  logic [W-1:0] opY = '0;
  logic         opSub = 1'b0;
  logic [W-1:0] resultDigits;
  logic         carryOut;
  logic         overflow;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_addsub #(.DIGITS(DIGITS)) dut (
    .opX          (opX),
    .opY          (opY),
    .opSub        (opSub),
    .resultDigits (resultDigits),
    .carryOut     (carryOut),
    .overflow     (overflow)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    string        tag;
  } item_t;

  item_t sbq[$];

  function automatic logic [W-1:0] toBcd(input longint v);
    logic [W-1:0] r;
    longint t;
    t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint sgn(input longint u);
    return (u >= HALF) ? u - MODULUS : u;
  endfunction

  function automatic longint randDec();
    longint acc;
    acc = 0;
    for (int i = 0; i < DIGITS; i++) acc = acc * 10 + longint'($urandom_range(9));
    return acc;
  endfunction

  // Driver: apply one operation and push its expected outcome.
  task automatic drive(input longint xv, input longint yv, input logic sub, input string tag);
    item_t  it;
    longint s;
    longint st;
    if (sub) begin
      s     = xv - yv + MODULUS;
      it.cy = (xv >= yv);
      st    = sgn(xv) - sgn(yv);
    end else begin
      s     = xv + yv;
      it.cy = (s >= MODULUS);
      st    = sgn(xv) + sgn(yv);
    end
    it.res = toBcd(s % MODULUS);
    it.ov  = (st >= HALF) || (st < -HALF);
    it.tag = tag;
    @(negedge clk);
    opX   = toBcd(xv);
    opY   = toBcd(yv);
    opSub = sub;
    sbq.push_back(it);
  endtask

  // Monitor: compare one cycle after each applied operation, off the edge.
  always @(posedge clk) begin
    #1;
    if (!rst && sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      total++;
      if (resultDigits !== it.res) begin
        bad++;
        $display("FAIL %s result act=%h exp=%h", it.tag, resultDigits, it.res);
      end
      total++;
      if (carryOut !== it.cy) begin
        bad++;
        $display("FAIL %s carryOut act=%0b exp=%0b", it.tag, carryOut, it.cy);
      end
      total++;
      if (overflow !== it.ov) begin
        bad++;
        $display("FAIL %s overflow act=%0b exp=%0b", it.tag, overflow, it.ov);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Reset state: zero plus zero (R1).
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (resultDigits !== '0 || carryOut !== 1'b0 || overflow !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset act=%h/%0b/%0b exp=0/0/0", resultDigits, carryOut, overflow);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(1, 1, 1'b0, "R1 small add");
    drive(12345678, 0, 1'b0, "R1 add zero");
    drive(38275619, 6172845, 1'b0, "R1 mixed carries");
    drive(99999999, 1, 1'b0, "R7 full ripple");
    drive(99999999, 99999999, 1'b0, "R4 add carry out");
    drive(49999999, 1, 1'b0, "R3 positive overflow");
    drive(40000000, 10000000, 1'b0, "R5 sign boundary overflow");
    drive(49999999, 0, 1'b0, "R5 largest positive");
    drive(50000000, 99999999, 1'b0, "R3 negative overflow");
    drive(50000000, 0, 1'b0, "R5 most negative kept");
    drive(3, 5, 1'b1, "R2 negative difference");
    drive(5, 3, 1'b1, "R4 no borrow");
    drive(0, 50000000, 1'b1, "R6 negate most negative");
    drive(99999999, 50000000, 1'b1, "R6 minus one minus most negative");
    drive(50000000, 50000000, 1'b1, "R8 self subtract extreme");
    drive(0, 1, 1'b1, "R2 zero minus one");
    drive(49999999, 99999999, 1'b1, "R3 subtract overflow");

    for (int k = 0; k < 40; k++) begin
      longint a;
      a = randDec();
      drive(a, a, 1'b1, "R8 self subtract");
    end
    for (int k = 0; k < 300; k++) drive(randDec(), randDec(), 1'b0, "R1 random add");
    for (int k = 0; k < 300; k++) drive(randDec(), randDec(), 1'b1, "R2 random subtract");

    while (sbq.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule